// File: doc/BRIEF.md
# Masked Phase-Shift Gate Generator

This block drives the eight gates of a bidirectional isolated converter built from two full bridges joined by a transformer. A free-running counter defines the switching period. The primary bridge is driven with a plain half-period square wave. The secondary bridge gets the same square wave, moved later by a programmable shift for forward power flow or moved earlier for reverse flow.

At light load, an off-window is cut into each half period of one bridge. In buck mode the window is cut into the primary bridge and spans from the supplied boundary up to the shift. In boost mode it is cut into the secondary bridge and spans from the boundary to the end of the half period. When the boundary moves past the end of its allowed interval, the window vanishes and the outputs become the conventional phase-shift waveforms. No step or glitch appears at that change.

Each switch's turn-on is delayed by a dead time, and this includes the turn-on edges that the window creates. Control values are accepted only at a period boundary, so every period is produced whole from a single set of settings.

Top module: `dab_masked_gate_gen`

## Requirements
- R1: While `rst` is high, and in every cycle in which `en` is sampled low, all eight gates are driven low on the following clock edge. While disabled, the period counter is held at 0.
- R2: The counter `t` runs from 0 to PERIOD-1 and then wraps. Let H = PERIOD/2. The primary bridge polarity is 1 when t < H. Gate bit 2k is the high side and bit 2k+1 the low side of leg k. Legs 0 and 1 are primary and legs 2 and 3 are secondary. With polarity p, leg 0 requests hi=p, lo=!p, and leg 1 requests hi=!p, lo=p. Legs 2 and 3 follow the same rule using the secondary polarity.
- R3: The secondary polarity is 1 when ts < H. With `reverse_sel`=0 (forward), ts = (t - phi) mod PERIOD. With `reverse_sel`=1, ts = (t + phi) mod PERIOD.
- R4: A shift value above H is used as H.
- R5: In buck mode (`boost_sel`=0), let r = t mod H. All four primary requests are removed while bound <= r < phi. The secondary bridge is unaffected.
- R6: In buck mode with bound >= phi, no window is cut, and the primary follows R2 unchanged.
- R7: In boost mode (`boost_sel`=1) with bound < H, all four secondary requests are removed while r >= max(bound, phi). The primary bridge is unaffected.
- R8: In boost mode with bound >= H, no window is cut.
- R9: The shift, bound, mode and direction inputs take effect only from the first cycle of a period (t = 0), or after a disabled interval. Changes made in the middle of a period have no effect on the current period.
- R10: A gate goes high only on the (DEAD+1)-th consecutive clock edge at which its request is present. It drops on the first edge at which the request is absent.
- R11: The high and low gate of one leg are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces all gates off |
| phi_cnt | input | CW | Bridge-to-bridge shift in clock counts |
| bound_cnt | input | CW | Window boundary (A in buck, B in boost) in clock counts |
| boost_sel | input | 1 | 0 = buck (primary windowed), 1 = boost (secondary windowed) |
| reverse_sel | input | 1 | 0 = secondary lags (forward), 1 = secondary leads (reverse) |
| gate | output | 8 | Gate drives, bit 2k = leg k high side, bit 2k+1 = leg k low side |

## Verification
A counter or latched setting that goes wrong moves or stretches a gate edge. That error appears at the ports within one period, and usually within a few cycles of the affected edge. A fault in a dead-time counter shows at the very next turn-on, as an edge one or more cycles early or late. The bench compares all eight gates in every cycle against an arithmetic model. It sweeps both modes, both directions, and shifts and boundaries on both sides of the collapse points. Configuration changes are made in the middle of a period, so any early latching shows up in the same period.

// File: rtl/dab_gate_pkg.sv
package dab_gate_pkg;

    typedef enum logic {
        MODE_BUCK  = 1'b0,
        MODE_BOOST = 1'b1
    } conv_mode_e;

    typedef enum logic {
        FLOW_FWD = 1'b0,
        FLOW_REV = 1'b1
    } flow_dir_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } leg_drive_t;

    // Complementary leg request; a kill removes both sides.
    function automatic leg_drive_t leg_drive(input logic pol, input logic kill);
        leg_drive_t d;
        d.hi = pol & ~kill;
        d.lo = ~pol & ~kill;
        return d;
    endfunction

endpackage

// File: rtl/dab_period_timer.sv
module dab_period_timer
    import dab_gate_pkg::*;
#(
    parameter int PERIOD = 5000,
    parameter int CW     = 13
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] phi_in,
    input  logic [CW-1:0] bnd_in,
    input  logic          boost_in,
    input  logic          rev_in,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] phi_q,
    output logic [CW-1:0] bnd_q,
    output conv_mode_e    mode_q,
    output flow_dir_e     dir_q
);
    localparam logic [CW-1:0] HALF_C = CW'(PERIOD / 2);
    localparam logic [CW-1:0] LAST_C = CW'(PERIOD - 1);

    logic [CW-1:0] phi_lim;
    logic          load;

    assign phi_lim = (phi_in > HALF_C) ? HALF_C : phi_in;
    assign load    = ~en | (cnt == LAST_C);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            phi_q  <= '0;
            bnd_q  <= '0;
            mode_q <= MODE_BUCK;
            dir_q  <= FLOW_FWD;
        end else begin
            if (load) cnt <= '0;
            else      cnt <= cnt + 1'b1;
            if (load) begin
                phi_q  <= phi_lim;
                bnd_q  <= bnd_in;
                mode_q <= conv_mode_e'(boost_in);
                dir_q  <= flow_dir_e'(rev_in);
            end
        end
    end

    a_r2_count_range: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_C);
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (en && cnt == LAST_C) |=> (cnt == '0));
    a_r1_hold_zero: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt == '0));
    a_r9_cfg_steady: assert property (@(posedge clk) disable iff (rst)
        (en && cnt != LAST_C) |=> ($stable(phi_q) && $stable(bnd_q) && $stable(mode_q) && $stable(dir_q)));
    a_r4_phi_clamped: assert property (@(posedge clk) disable iff (rst)
        phi_q <= HALF_C);

endmodule

// File: rtl/dab_wave_shaper.sv
module dab_wave_shaper
    import dab_gate_pkg::*;
#(
    parameter int PERIOD = 5000,
    parameter int CW     = 13
) (
    input  logic             [CW-1:0] t,
    input  logic             [CW-1:0] phi,
    input  logic             [CW-1:0] bnd,
    input  conv_mode_e                mode,
    input  flow_dir_e                 dir,
    output leg_drive_t [3:0]          legs
);
    localparam logic [CW:0]   PER_X  = (CW+1)'(PERIOD);
    localparam logic [CW:0]   HALF_X = (CW+1)'(PERIOD / 2);
    localparam logic [CW-1:0] HALF_C = CW'(PERIOD / 2);

    logic [CW:0]   t_x, phi_x, sum_x, ts;
    logic [CW-1:0] r, bnd_lo;
    logic          prim_pol, sec_pol, buck_kill, boost_kill;

    always_comb begin
        t_x   = {1'b0, t};
        phi_x = {1'b0, phi};
        prim_pol = (t < HALF_C);
        r = prim_pol ? t : (t - HALF_C);

        if (dir == FLOW_REV) begin
            sum_x = t_x + phi_x;
            ts    = (sum_x >= PER_X) ? (sum_x - PER_X) : sum_x;
        end else begin
            sum_x = t_x + PER_X;
            ts    = (t_x >= phi_x) ? (t_x - phi_x) : (sum_x - phi_x);
        end
        sec_pol = (ts < HALF_X);

        bnd_lo     = (bnd > phi) ? bnd : phi;
        buck_kill  = (mode == MODE_BUCK) && (bnd < phi) && (r >= bnd) && (r < phi);
        boost_kill = (mode == MODE_BOOST) && (bnd < HALF_C) && (r >= bnd_lo);

        legs[0] = leg_drive(prim_pol, buck_kill);
        legs[1] = leg_drive(~prim_pol, buck_kill);
        legs[2] = leg_drive(sec_pol, boost_kill);
        legs[3] = leg_drive(~sec_pol, boost_kill);
    end

endmodule

// File: rtl/dab_dead_band.sv
module dab_dead_band
    import dab_gate_pkg::*;
#(
    parameter int DEAD = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  leg_drive_t req,
    output leg_drive_t drv
);
    localparam int RW = $clog2(DEAD + 1);
    localparam logic [RW-1:0] DEAD_C = RW'(DEAD);

    logic [1:0] req_v, drv_v;

    assign req_v = {req.hi, req.lo};
    assign drv   = '{hi: drv_v[1], lo: drv_v[0]};

    for (genvar s = 0; s < 2; s++) begin : g_side
        logic [RW-1:0] run;
        always_ff @(posedge clk) begin
            if (rst || !en || !req_v[s]) begin
                run      <= '0;
                drv_v[s] <= 1'b0;
            end else begin
                drv_v[s] <= (run == DEAD_C);
                if (run != DEAD_C) run <= run + 1'b1;
            end
        end
    end

    a_r11_leg_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(drv.hi && drv.lo));
    a_r10_rise_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(drv.hi) |-> $past(req.hi));
    a_r10_drop_at_once: assert property (@(posedge clk) disable iff (rst)
        !req.lo |=> !drv.lo);

endmodule

// File: rtl/dab_masked_gate_gen.sv
module dab_masked_gate_gen
    import dab_gate_pkg::*;
#(
    parameter  int PERIOD = 5000,
    parameter  int DEAD   = 100,
    localparam int CW     = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [CW-1:0] phi_cnt,
    input  logic [CW-1:0] bound_cnt,
    input  logic          boost_sel,
    input  logic          reverse_sel,
    output logic [7:0]    gate
);
    logic       [CW-1:0] t, phi_q, bnd_q;
    conv_mode_e          mode_q;
    flow_dir_e           dir_q;
    leg_drive_t [3:0]    req, drv;

    dab_period_timer #(.PERIOD(PERIOD), .CW(CW)) u_timer (
        .clk(clk), .rst(rst), .en(en),
        .phi_in(phi_cnt), .bnd_in(bound_cnt),
        .boost_in(boost_sel), .rev_in(reverse_sel),
        .cnt(t), .phi_q(phi_q), .bnd_q(bnd_q),
        .mode_q(mode_q), .dir_q(dir_q)
    );

    dab_wave_shaper #(.PERIOD(PERIOD), .CW(CW)) u_shaper (
        .t(t), .phi(phi_q), .bnd(bnd_q),
        .mode(mode_q), .dir(dir_q), .legs(req)
    );

    for (genvar k = 0; k < 4; k++) begin : g_leg
        dab_dead_band #(.DEAD(DEAD)) u_db (
            .clk(clk), .rst(rst), .en(en),
            .req(req[k]), .drv(drv[k])
        );
        assign gate[2*k]   = drv[k].hi;
        assign gate[2*k+1] = drv[k].lo;
    end

    a_r1_off_when_disabled: assert property (@(posedge clk) disable iff (rst)
        !en |=> (gate == 8'h00));
    a_r5_buck_spares_secondary: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_BUCK) |-> ((req[2].hi | req[2].lo) && (req[3].hi | req[3].lo)));
    a_r7_boost_spares_primary: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_BOOST) |-> ((req[0].hi | req[0].lo) && (req[1].hi | req[1].lo)));

endmodule

// File: tb/tb_dab_masked_gate_gen.sv
`timescale 1ns/1ps
module tb_dab_masked_gate_gen;
    localparam int P  = 40;
    localparam int H  = P / 2;
    localparam int D  = 2;
    localparam int CW = $clog2(P);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic [CW-1:0] phi = '0;
    logic [CW-1:0] bnd = '0;
    logic          boost = 1'b0;
    logic          rev   = 1'b0;
    wire  [7:0]    gate;

    always #2.5 clk = ~clk;

    dab_masked_gate_gen #(.PERIOD(P), .DEAD(D)) dut (
        .clk(clk), .rst(rst), .en(en), .phi_cnt(phi), .bound_cnt(bnd),
        .boost_sel(boost), .reverse_sel(rev), .gate(gate)
    );

    int    checks = 0;
    int    fails  = 0;
    string tag    = "R1";

    int       m_cnt = 0, m_phi = 0, m_bnd = 0;
    bit       m_boost = 0, m_rev = 0;
    int       m_run[8];
    bit [7:0] m_out = '0;

    function automatic bit [7:0] req_now();
        bit [7:0] q;
        int  r, ts, lo;
        bit  pp, sp, kp, ks;
        pp = (m_cnt < H);
        r  = m_cnt % H;
        ts = m_rev ? (m_cnt + m_phi) % P : (m_cnt + P - m_phi) % P;
        sp = (ts < H);
        lo = (m_bnd > m_phi) ? m_bnd : m_phi;
        kp = !m_boost && (r >= m_bnd) && (r < m_phi);
        ks = m_boost && (m_bnd < H) && (r >= lo);
        q[0] = pp && !kp;  q[1] = !pp && !kp;
        q[2] = !pp && !kp; q[3] = pp && !kp;
        q[4] = sp && !ks;  q[5] = !sp && !ks;
        q[6] = !sp && !ks; q[7] = sp && !ks;
        return q;
    endfunction

    task automatic step();
        bit [7:0] rq, nx;
        rq = req_now();
        for (int g = 0; g < 8; g++) begin
            if (rst || !en || !rq[g]) begin
                nx[g] = 1'b0;
                m_run[g] = 0;
            end else begin
                nx[g] = (m_run[g] == D);
                if (m_run[g] < D) m_run[g]++;
            end
        end
        if (rst) begin
            m_cnt = 0; m_phi = 0; m_bnd = 0; m_boost = 0; m_rev = 0;
        end else if (!en || m_cnt == P - 1) begin
            m_cnt = 0;
            m_phi = (int'(phi) > H) ? H : int'(phi);
            m_bnd = int'(bnd); m_boost = boost; m_rev = rev;
        end else begin
            m_cnt++;
        end
        m_out = nx;
    endtask

    task automatic check_now();
        checks++;
        if (gate !== m_out) begin
            fails++;
            $display("FAIL %s: gate=%b expected %b", tag, gate, m_out);
        end
        checks++;
        for (int k = 0; k < 4; k++) begin
            if (gate[2*k] && gate[2*k+1]) begin
                fails++;
                $display("FAIL R11: leg %0d gates=%b%b expected not both 1", k, gate[2*k+1], gate[2*k]);
            end
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            step();
            @(negedge clk);
            check_now();
        end
    endtask

    bit done = 0;
    initial begin
        #(200000 * 5.0);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int phis[6] = '{0, 3, 8, 15, 20, 25};
        int bnds[6] = '{0, 5, 12, 19, 20, 30};
        for (int g = 0; g < 8; g++) m_run[g] = 0;

        tag = "R1 reset";
        tick(3);
        rst = 1'b0;
        tag = "R1 disabled";
        tick(5);

        en = 1'b1;
        for (int md = 0; md < 2; md++) begin
            for (int dr = 0; dr < 2; dr++) begin
                for (int i = 0; i < 6; i++) begin
                    for (int j = 0; j < 6; j++) begin
                        boost = md[0]; rev = dr[0];
                        phi = CW'(phis[i]); bnd = CW'(bnds[j]);
                        tag = $sformatf("R2/R3/R10 %s %s phi=%0d bnd=%0d",
                                        md ? "R7/R8" : "R5/R6",
                                        (phis[i] > H) ? "R4" : "-", phis[i], bnds[j]);
                        tick(3 * P);
                    end
                end
            end
        end

        tag = "R9 mid-period change";
        boost = 1'b0; rev = 1'b0; phi = CW'(8); bnd = CW'(3);
        tick(2 * P);
        while (m_cnt != 10) tick(1);
        phi = CW'(15); bnd = CW'(6); boost = 1'b1; rev = 1'b1;
        tick(2 * P);

        tag = "R1 enable drop";
        en = 1'b0;
        tick(10);
        en = 1'b1;
        tag = "R1 restart";
        tick(2 * P);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule